// File: doc/BRIEF.md
# Nine-Level Inverter Gate Pattern Generator

This block drives the eight switches of a single-phase inverter. The inverter has two cascaded sub-modules with binary-weighted DC links, which build the level magnitude, followed by a full bridge that sets the output sign. A signed reference sample arrives on every clock. The block rectifies it and compares the magnitude against four stacked triangular carriers, all in phase. The number of carriers the magnitude exceeds gives the output level, from 0 to 4. That level is then translated into the sub-module switch code.

The bridge runs at line frequency. A polarity state machine follows the sign bit of the reference with one sample of hysteresis. Its states are:
- `PS_OFF`: after reset, all gates off.
- `PS_POS`: positive polarity.
- `PS_POS_PEND`: positive polarity, one negative sample seen.
- `PS_NEG`: negative polarity.
- `PS_NEG_PEND`: negative polarity, one non-negative sample seen.

Its transitions are:
- START: `PS_OFF` goes to `PS_POS` or `PS_NEG` from the sign of the first sample.
- SUSPECT: `PS_POS` goes to `PS_POS_PEND` on a negative sample, and `PS_NEG` goes to `PS_NEG_PEND` on a non-negative sample.
- CONFIRM: from a pending state, a second sample of the new sign moves to the opposite polarity (`PS_POS_PEND` to `PS_NEG`, `PS_NEG_PEND` to `PS_POS`).
- CANCEL: from a pending state, a sample of the old sign returns to the steady state.

All gate outputs are registered.

Top module: `mlpwm_top`

## Requirements
- R1: While reset is high, and until the first clock edge after it is released, both gate outputs are 0000.
- R2: The carrier ramp starts at 0 at the first edge after reset. It counts up by one per clock to PEAK, then down to 0, so one carrier period is 2·PEAK clocks. PEAK = CLK_HZ / (CARRIER_RATIO·LINE_HZ·2).
- R3: Carrier k (k = 0..3) fills the k-th quarter of full scale FS = 2^(REF_W-1). Pulse k is set when |ref|·4·PEAK > (k·PEAK + ramp)·FS. The level is the number of set pulses, and the pulses always form a thermometer code.
- R4: One clock after the sample, `lvl_gate_o` = {Sa1,Sb1,Sa2,Sb2} carries 0000, 0101, 1001, 0110 or 1010 for levels 0, 1, 2, 3 and 4 respectively.
- R5: Sa1 and Sb1 are never both set, and Sa2 and Sb2 are never both set.
- R6: `hb_gate_o` = {SH1,SH2,SH3,SH4} is 1100 for positive polarity and 0011 for negative polarity when the level is non-zero. At level 0 it freewheels with 1010 for positive polarity and 0101 for negative polarity.
- R7: SH1 and SH4 change only in a cycle where the registered polarity changes, or on leaving `PS_OFF`.
- R8: A sign bit of 0 means positive. Polarity reverses only after two consecutive samples of the opposite sign. The first sample after reset sets polarity directly.
- R9: At most four gates are on at once. Outside `PS_OFF`, exactly two bridge gates are on.
- R10: Outside `PS_OFF`, the bridge shows a freewheel pattern exactly when the level-generator gates are 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one reference sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | REF_W | Signed two's-complement reference sample |
| lvl_gate_o | output | 4 | Sub-module gates {Sa1,Sb1,Sa2,Sb2} |
| hb_gate_o | output | 4 | Bridge gates {SH1,SH2,SH3,SH4} |

## Verification
Some properties are checked on every cycle by assertions:
- the ramp stays within range and moves by exactly one step;
- the carrier pulses stay a thermometer code;
- the two switches of a sub-module are never on together;
- the gate count stays within bounds and the freewheel pattern matches a zero level code;
- the bridge legs SH1 and SH4 move only with a polarity change, and a polarity change is backed by two agreeing sign samples.

Other behaviours only the bench scenarios can show. These are the exact level thresholds at each ramp value, the level-to-code table, and the timing of the one-sample hysteresis against an isolated sign glitch. The bench shows them with a sampled sine, a sweep of magnitudes over a whole carrier period, and a mid-run reset.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

    localparam int N_BANDS = 4;

    typedef enum logic [2:0] {
        PS_OFF,
        PS_POS,
        PS_POS_PEND,
        PS_NEG,
        PS_NEG_PEND
    } pol_state_t;

    // Level (0..4) to {Sa1,Sb1,Sa2,Sb2}
    function automatic logic [3:0] level_code(input logic [2:0] lvl);
        logic [3:0] code;
        unique case (lvl)
            3'd1:    code = 4'b0101;
            3'd2:    code = 4'b1001;
            3'd3:    code = 4'b0110;
            3'd4:    code = 4'b1010;
            default: code = 4'b0000;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier #(
    parameter int PEAK = 400,
    parameter int CW   = $clog2(PEAK + 1)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] ramp_o
);

    logic          up_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (up_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(PEAK - 1)) up_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) up_q <= 1'b1;
        end
    end

    assign ramp_o = cnt_q;

    // R2
    ramp_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= PEAK);

    // R2
    ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((int'(cnt_q) == int'($past(cnt_q)) + 1) ||
                         (int'(cnt_q) + 1 == int'($past(cnt_q)))));

    // R2
    ramp_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt_q) == PEAK) |=> (int'(cnt_q) == PEAK - 1));

endmodule

// File: rtl/mlpwm_cmp_bank.sv
module mlpwm_cmp_bank
    import mlpwm_pkg::*;
#(
    parameter int REF_W = 12,
    parameter int PEAK  = 400,
    parameter int CW    = $clog2(PEAK + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REF_W-1:0] mag_i,
    input  logic [CW-1:0]    ramp_i,
    output logic [N_BANDS-1:0] pulse_o,
    output logic [2:0]       level_o
);

    localparam int PW = REF_W + CW + 4;

    logic [PW-1:0] scaled;
    assign scaled = PW'(mag_i) * PW'(N_BANDS * PEAK);

    for (genvar k = 0; k < N_BANDS; k++) begin : g_band
        logic [PW-1:0] carrier;
        assign carrier    = (PW'(k * PEAK) + PW'(ramp_i)) << (REF_W - 1);
        assign pulse_o[k] = (scaled > carrier);
    end

    assign level_o = 3'($countones(pulse_o));

    // R3
    p_therm_chk: assert property (@(posedge clk) disable iff (rst)
        ((pulse_o & (pulse_o + 1'b1)) == '0));

endmodule

// File: rtl/mlpwm_pol_fsm.sv
module mlpwm_pol_fsm
    import mlpwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic neg_i,
    output logic pos_d_o,
    output logic on_d_o,
    output logic pos_q_o,
    output logic on_q_o
);

    pol_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= PS_OFF;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_OFF:      st_d = neg_i ? PS_NEG : PS_POS;
            PS_POS:      st_d = neg_i ? PS_POS_PEND : PS_POS;
            PS_POS_PEND: st_d = neg_i ? PS_NEG : PS_POS;
            PS_NEG:      st_d = neg_i ? PS_NEG : PS_NEG_PEND;
            PS_NEG_PEND: st_d = neg_i ? PS_NEG : PS_POS;
            default:     st_d = PS_OFF;
        endcase
    end

    assign pos_d_o = (st_d == PS_POS) || (st_d == PS_POS_PEND);
    assign on_d_o  = (st_d != PS_OFF);
    assign pos_q_o = (st_q == PS_POS) || (st_q == PS_POS_PEND);
    assign on_q_o  = (st_q != PS_OFF);

    // R8
    pol_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (on_q_o && $past(on_q_o) && (pos_q_o != $past(pos_q_o))) |->
        (($past(neg_i) == !pos_q_o) && ($past(neg_i, 2) == !pos_q_o)));

endmodule

// File: rtl/mlpwm_top.sv
module mlpwm_top
    import mlpwm_pkg::*;
#(
    parameter int REF_W         = 12,
    parameter int CLK_HZ        = 1_040_000,
    parameter int LINE_HZ       = 50,
    parameter int CARRIER_RATIO = 26
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [REF_W-1:0] ref_i,
    output logic [3:0]              lvl_gate_o,
    output logic [3:0]              hb_gate_o
);

    localparam int PEAK = CLK_HZ / (CARRIER_RATIO * LINE_HZ * 2);
    localparam int CW   = $clog2(PEAK + 1);

    logic [REF_W-1:0]   ref_u;
    logic [REF_W-1:0]   mag;
    logic [CW-1:0]      ramp;
    logic [N_BANDS-1:0] pulse;
    logic [2:0]         level;
    logic               pos_d, on_d, pos_q, on_q;
    logic [3:0]         lg_d, hb_d;

    assign ref_u = ref_i;
    assign mag   = ref_u[REF_W-1] ? (~ref_u + 1'b1) : ref_u;

    mlpwm_carrier #(.PEAK(PEAK), .CW(CW)) u_carrier (
        .clk    (clk),
        .rst    (rst),
        .ramp_o (ramp)
    );

    mlpwm_cmp_bank #(.REF_W(REF_W), .PEAK(PEAK), .CW(CW)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .mag_i   (mag),
        .ramp_i  (ramp),
        .pulse_o (pulse),
        .level_o (level)
    );

    mlpwm_pol_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .neg_i   (ref_u[REF_W-1]),
        .pos_d_o (pos_d),
        .on_d_o  (on_d),
        .pos_q_o (pos_q),
        .on_q_o  (on_q)
    );

    // Output decode for the state entered at this edge
    always_comb begin
        if (!on_d) begin
            lg_d = 4'b0000;
            hb_d = 4'b0000;
        end else if (level == 3'd0) begin
            lg_d = 4'b0000;
            hb_d = pos_d ? 4'b1010 : 4'b0101;
        end else begin
            lg_d = level_code(level);
            hb_d = pos_d ? 4'b1100 : 4'b0011;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_gate_o <= 4'b0000;
            hb_gate_o  <= 4'b0000;
        end else begin
            lvl_gate_o <= lg_d;
            hb_gate_o  <= hb_d;
        end
    end

    // R5
    sub_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(lvl_gate_o[3] && lvl_gate_o[2]) && !(lvl_gate_o[1] && lvl_gate_o[0]));

    // R7
    leg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((hb_gate_o[3] != $past(hb_gate_o[3])) || (hb_gate_o[0] != $past(hb_gate_o[0])))
        |-> ((pos_q != $past(pos_q)) || !$past(on_q)));

    // R9
    gate_count_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones({lvl_gate_o, hb_gate_o}) <= 4) &&
        (!on_q || ($countones(hb_gate_o) == 2)));

    // R10
    freewheel_chk: assert property (@(posedge clk) disable iff (rst)
        on_q |-> ((lvl_gate_o == 4'b0000) ==
                  ((hb_gate_o == 4'b1010) || (hb_gate_o == 4'b0101))));

endmodule

// File: tb/sim_mlpwm_top.sv
module sim_mlpwm_top;

    localparam int CLK_PERIOD = 10;
    localparam int REF_W      = 12;
    localparam int CLK_HZ     = 41_600;
    localparam int PEAK       = CLK_HZ / (26 * 50 * 2);
    localparam int FS         = 1 << (REF_W - 1);
    localparam int FUND       = 26 * 2 * PEAK;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic signed [REF_W-1:0] ref_v = '0;
    logic [3:0]              lvl_gate, hb_gate;

    int n_chk  = 0;
    int n_fail = 0;
    int edge_k = 0;
    int mst    = 0;   // 0 off, 1 pos, 2 pos pending, 3 neg, 4 neg pending

    always #(CLK_PERIOD / 2) clk = ~clk;

    mlpwm_top #(.REF_W(REF_W), .CLK_HZ(CLK_HZ)) u0 (
        .clk        (clk),
        .rst        (rst),
        .ref_i      (ref_v),
        .lvl_gate_o (lvl_gate),
        .hb_gate_o  (hb_gate)
    );

    task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at edge %0d: actual %b expected %b", tag, edge_k, act, exp);
        end
    endtask

    function automatic int ramp_at(input int k);
        int m;
        m = k % (2 * PEAK);
        return (m <= PEAK) ? m : 2 * PEAK - m;
    endfunction

    function automatic int level_of(input int r, input int t);
        int mag, lv;
        mag = (r < 0) ? -r : r;
        lv  = 0;
        for (int k = 0; k < 4; k++)
            if (mag * 4 * PEAK > (k * PEAK + t) * FS) lv++;
        return lv;
    endfunction

    function automatic logic [3:0] code_of(input int lv);
        case (lv)
            1: return 4'b0101;
            2: return 4'b1001;
            3: return 4'b0110;
            4: return 4'b1010;
            default: return 4'b0000;
        endcase
    endfunction

    // Drive one sample, let one edge pass, compare against the model (R2 R3 R4 R6 R8 R9)
    task automatic step(input int r);
        int lv;
        bit neg, pos;
        logic [3:0] exp_lg, exp_hb;
        ref_v = REF_W'(r);
        neg   = (r < 0);
        lv    = level_of(r, ramp_at(edge_k));
        case (mst)
            0: mst = neg ? 3 : 1;
            1: mst = neg ? 2 : 1;
            2: mst = neg ? 3 : 1;
            3: mst = neg ? 3 : 4;
            default: mst = neg ? 3 : 1;
        endcase
        pos    = (mst == 1) || (mst == 2);
        exp_lg = code_of(lv);
        if (lv == 0) exp_hb = pos ? 4'b1010 : 4'b0101;
        else         exp_hb = pos ? 4'b1100 : 4'b0011;
        @(posedge clk);
        #1;
        check4("R2/R3/R4 level code", lvl_gate, exp_lg);
        check4("R6/R8 bridge pattern", hb_gate, exp_hb);
        n_chk++;
        if ($countones({lvl_gate, hb_gate}) > 4) begin
            n_fail++;
            $display("FAIL R9 gate count: actual %0d expected <= 4",
                     $countones({lvl_gate, hb_gate}));
        end
        edge_k++;
    endtask

    task automatic restart();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check4("R1 reset lvl", lvl_gate, 4'b0000);
        check4("R1 reset bridge", hb_gate, 4'b0000);
        rst    = 1'b0;
        edge_k = 0;
        mst    = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        real ph;
        restart();

        // Sampled sine, two fundamental periods
        for (int i = 0; i < 2 * FUND; i++) begin
            ph = 2.0 * 3.14159265358979 * real'(i) / real'(FUND);
            step($rtoi(1950.0 * $sin(ph)));
        end

        // Magnitude sweep, each value held over one whole carrier period
        for (int v = -FS; v < FS; v += 16)
            repeat (2 * PEAK) step(v);

        // Extremes
        repeat (2 * PEAK) step(-FS);
        repeat (2 * PEAK) step(FS - 1);

        // Hysteresis: a lone negative sample must not flip the bridge (R8)
        repeat (40) step(600);
        step(-600);
        check4("R8 glitch holds SH1", {3'b000, hb_gate[3]}, 4'b0001);
        step(600);
        check4("R7 SH4 stays off", {3'b000, hb_gate[0]}, 4'b0000);
        step(-600);
        step(-600);
        check4("R8 two samples flip to SH4", {3'b000, hb_gate[0]}, 4'b0001);

        // Mid-run reset, then a negative first sample sets polarity at once (R8)
        restart();
        step(-1200);
        check4("R8 first sample negative", hb_gate, 4'b0011);
        repeat (3 * PEAK) step(-300);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule